// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external 64K x 8 asynchronous static RAM. The host raises a request with a 16-bit address, a direction flag and, for writes, an 8-bit data byte. It holds that request until the controller returns a one-clock acknowledge. For reads, the acknowledge comes with the returned byte.

The controller turns each request into a pin sequence on the memory side. That side has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and a shared 8-bit data bus. Every minimum or maximum time the memory needs is given in nanoseconds as a parameter. Each one is rounded up to whole clocks of the `CLK_NS` period.

A write that follows a read first waits a number of idle clocks. This lets the memory stop driving the bus before the controller drives write data onto it. With the defaults (4 ns clock), the counts are:

- read phase: 25 clocks
- write strobe: 20 clocks
- write phase: 25 clocks
- turnaround: 9 clocks

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and right after reset the memory pins are idle: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, and ack=0.
- R2: A read keeps the chip selected, mem_oe_n low and mem_we_n high for 25 clocks, starting at the edge that accepts the request. The byte on mem_dq in the last of those clocks is returned on rdata.
- R3: ack is high for exactly one clock. It rises 25 edges after the accepting edge for a read, 25 for a write, and 34 for a write whose previous operation was a read.
- R4: A write holds mem_we_n low for exactly 20 clocks from the accepting edge, with mem_oe_n high throughout.
- R5: The controller drives the host's write byte on mem_dq only while mem_we_n is low, and releases the bus at the edge where mem_we_n rises.
- R6: mem_addr is stable while mem_we_n is low and for at least 2 clocks after it rises, with the chip still selected.
- R7: A write that follows a read waits 9 idle clocks, with all pins inactive, before mem_we_n falls. The memory's trailing bus drive after a read therefore never overlaps a write.
- R8: A byte written to an address is returned by any later read of that address.
- R9: mem_we_n and mem_oe_n are never low at the same time.
- R10: A request that is still high in the clock where ack is high is ignored. No new memory cycle starts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 8 | Write byte |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 16 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
The hardest situation to reach from the ports is a read followed by a write while the memory is still driving the bus after its output enable has gone high. The bench's memory model keeps driving for 9 clocks after every read. It also drives a wrong byte until the full access time has elapsed, so the controller must capture late and wait before writing. Random mixes of reads and writes over a small address pool create many read-then-write pairs. A few directed operations hold the request high through the acknowledge clock.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int CLK_NS = 4,
  parameter int T_RC   = 100,
  parameter int T_AA   = 100,
  parameter int T_OE   = 50,
  parameter int T_OHZ  = 35,
  parameter int T_WC   = 100,
  parameter int T_WP   = 70,
  parameter int T_AW   = 80,
  parameter int T_DW   = 40,
  parameter int T_WR   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        ack,
  output logic [7:0]  rdata,
  output logic [15:0] mem_addr,
  output logic        mem_ce_n,
  output logic        mem_ce,
  output logic        mem_we_n,
  output logic        mem_oe_n,
  inout  wire  [7:0]  mem_dq
);
  function automatic int cdiv(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RC_CYC = mx(mx(cdiv(T_RC), cdiv(T_AA)), mx(cdiv(T_OE), 1));
  localparam int WP_CYC = mx(mx(cdiv(T_WP), cdiv(T_AW)), mx(cdiv(T_DW), 1));
  localparam int WR_CYC = mx(cdiv(T_WR), 1);
  localparam int WC_CYC = mx(cdiv(T_WC), WP_CYC + WR_CYC);
  localparam int TA_CYC = mx(cdiv(T_OHZ), 1);
  localparam int MAXC   = mx(mx(RC_CYC, WC_CYC), TA_CYC);
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_READ, S_WRITE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        after_rd, sel, oe, we, drv, ack_q;
  logic [15:0] a_q;
  logic [7:0]  d_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; after_rd <= 1'b0;
      sel <= 1'b0; oe <= 1'b0; we <= 1'b0; drv <= 1'b0; ack_q <= 1'b0;
      a_q <= '0; d_q <= '0; rd_q <= '0;
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_IDLE: if (req && !ack_q) begin
          a_q <= addr; d_q <= wdata; cnt <= '0;
          if (!wr) begin
            st <= S_READ; sel <= 1'b1; oe <= 1'b1; after_rd <= 1'b1;
          end else if (after_rd) begin
            st <= S_TURN;
          end else begin
            st <= S_WRITE; sel <= 1'b1; we <= 1'b1; drv <= 1'b1;
          end
        end
        S_TURN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(TA_CYC - 1)) begin
            st <= S_WRITE; cnt <= '0; after_rd <= 1'b0;
            sel <= 1'b1; we <= 1'b1; drv <= 1'b1;
          end
        end
        S_READ: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RC_CYC - 1)) begin
            rd_q <= mem_dq; ack_q <= 1'b1;
            sel <= 1'b0; oe <= 1'b0; st <= S_IDLE;
          end
        end
        S_WRITE: begin
          cnt <= cnt + 1'b1;
          after_rd <= 1'b0;
          if (cnt == CW'(WP_CYC - 1)) begin
            we <= 1'b0; drv <= 1'b0;
          end
          if (cnt == CW'(WC_CYC - 1)) begin
            sel <= 1'b0; ack_q <= 1'b1; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack      = ack_q;
  assign rdata    = rd_q;
  assign mem_addr = a_q;
  assign mem_ce_n = ~sel;
  assign mem_ce   = sel;
  assign mem_we_n = ~we;
  assign mem_oe_n = ~oe;
  assign mem_dq   = drv ? d_q : 8'bz;

  // R9
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  // R5
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (we && sel));
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr));
  // R2
  read_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_ce));
  // R7
  turn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TURN) |-> (mem_ce_n && mem_we_n && mem_oe_n && !drv));
endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;
  localparam int RC = 25, WP = 20, WC = 25, TA = 9, WRC = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ack;
  logic [7:0] rdata;
  logic [15:0] mem_addr;
  logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n;
  wire [7:0] mem_dq;
  logic mdrv = 1'b0;
  logic [7:0] mval = '0;

  assign mem_dq = mdrv ? mval : 8'bz;

  always #2 clk = ~clk;

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

  int vectors = 0, errors = 0;
  logic [7:0] mdl [int];
  logic [7:0] ref_m [int];
  logic [7:0] cur_wd = '0;

  function automatic logic [7:0] init_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mdl_rd(logic [15:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] ref_rd(logic [15:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : init_val(a);
  endfunction
  function automatic int exp_lat(bit w, bit prev_rd);
    return (w ? (prev_rd ? TA + WC : WC) : RC) + 1;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  int wlow = 0, post = 0, rcnt = 0, hold = 0;
  logic [15:0] wa_q = '0;
  logic [7:0] wd_last = '0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) begin
      chk(mem_oe_n == 1'b1, "R9", mem_oe_n, 1);
      if (wlow > 0) chk(mem_addr == wa_q, "R6", mem_addr, wa_q);
      chk(mem_dq == cur_wd, "R5", mem_dq, cur_wd);
      wa_q = mem_addr; wd_last = mem_dq; wlow++;
    end else if (wlow > 0) begin
      chk(wlow == WP, "R4", wlow, WP);
      chk(mem_addr == wa_q && !mem_ce_n, "R6", mem_addr, wa_q);
      mdl[int'(wa_q)] = wd_last;
      wlow = 0; post = WRC - 1;
    end else if (post > 0) begin
      chk(mem_addr == wa_q && !mem_ce_n, "R6", mem_addr, wa_q);
      post--;
    end
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
      rcnt++;
      mdrv = 1'b1;
      mval = (rcnt >= RC) ? mdl_rd(mem_addr) : ~mdl_rd(mem_addr);
      hold = TA;
    end else begin
      rcnt = 0;
      if (hold > 0) begin
        chk(mem_we_n == 1'b1, "R7", mem_we_n, 1);
        hold--;
        if (hold == 0) mdrv = 1'b0;
      end else mdrv = 1'b0;
    end
  end

  bit prev_rd = 1'b0;

  task automatic op(bit w, logic [15:0] a, logic [7:0] d, bit linger);
    int n = 0;
    logic [7:0] e;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    if (w) cur_wd = d;
    e = ref_rd(a);
    forever begin
      @(negedge clk);
      n++;
      if (ack || n > 200) break;
    end
    // R3: latency and single-clock ack
    chk(n == exp_lat(w, prev_rd), "R3", n, exp_lat(w, prev_rd));
    if (!w) begin
      // R2 and R8: byte returned equals last byte written (or initial content)
      chk(rdata == e, "R2/R8", rdata, e);
    end else ref_m[int'(a)] = d;
    if (!linger) req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R3", ack, 0);
    if (linger) begin
      // R10: request still high in ack clock is ignored
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R10",
          {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      req = 1'b0;
      @(negedge clk);
      chk(mem_ce_n == 1'b1, "R10", mem_ce_n, 1);
    end
    prev_rd = !w;
  endtask

  initial begin
    logic [15:0] pool [8];
    pool = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001, 16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA};
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R1
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !ack, "R1",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, ack}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !ack, "R1",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, ack}, 5'b10110);
    op(1'b0, 16'h0000, 8'h00, 1'b0);
    op(1'b1, 16'hFFFF, 8'hA5, 1'b0);
    op(1'b1, 16'h0000, 8'h3C, 1'b0);
    op(1'b0, 16'hFFFF, 8'h00, 1'b1);
    op(1'b1, 16'h1234, 8'hFF, 1'b1);
    op(1'b0, 16'h1234, 8'h00, 1'b0);
    op(1'b0, 16'h0000, 8'h00, 1'b0);
    for (int i = 0; i < 300; i++) begin
      bit w = 1'($urandom);
      logic [15:0] a = pool[$urandom % 8];
      op(w, a, 8'($urandom), ($urandom % 10) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    vectors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule